// File: doc/BRIEF.md
# PS/2 Host Keyboard Controller Core

This core is the host-facing register block of a PC-style keyboard and auxiliary (mouse) controller. A byte-wide bus with a single address bit reaches two ports. Address 0 is the data port. Address 1 is the command port on writes and the status port on reads. The core holds a mode byte, a self-test flag, the A20 gate level and a pending write target. It decodes controller command bytes and steers data-port writes to the chosen destination. It pushes reply bytes into the keyboard or auxiliary outbound queue, picks which device stream a data read drains, and drives the two interrupt lines.

The serial device engines and their byte queues sit outside the core. Each queue shows the core a pending level and its head byte, and it takes a one-cycle pop strobe. Pushes and transmit bytes leave the core as one-cycle valid strobes.

Top module: `kbc_host_core`

## Requirements
- R1: After reset the mode byte is 0x03, `a20_gate` and `xlate_en` are 0, and a status read with no data pending returns 0x18.
- R2: Status bit 0 is 1 whenever either stream is pending. Status bit 5 is 1 only when the auxiliary stream is the only one pending. Status bit 2 is the self-test flag. Bits 3 and 4 read 1, and bits 1, 6 and 7 read 0.
- R3: `irq_aux` is high exactly when only the auxiliary stream is pending and mode bit 1 is set. `irq_kbd` is high exactly when keyboard data is pending, mode bit 0 is set and mode bit 4 is clear. Both are combinational from the pending inputs and the mode byte.
- R4: A data-port read returns `aux_rx_byte` and pulses `aux_pop` only when the auxiliary stream alone is pending. Otherwise it returns `kbd_rx_byte`, and it pulses `kbd_pop` if keyboard data is pending. The two pops are never high together.
- R5: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only record a target. The next data-port write then goes, in that order, to the mode byte, the output port, the keyboard reply queue, the auxiliary reply queue or the mouse transmit path. After that write the target returns to the keyboard transmit path.
- R6: Command 0x20 pushes the mode byte to the keyboard queue. Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00.
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, and `irq_kbd` follows from the next cycle.
- R8: Command 0xD0 pushes 0x01 | A20<<1 | OBF<<4 | AUXOBF<<5 to the keyboard queue, where OBF and AUXOBF are status bits 0 and 5 at the time of the command.
- R9: Command 0xDF sets A20 and 0xDD clears it. Command 0xFE pulses `sys_reset_req` for one cycle. An output-port write loads A20 from data bit 1 and pulses the reset request when data bit 0 is 0.
- R10: `xlate_en` equals mode bit 6.
- R11: Command 0xFF and every command byte not listed here change nothing. They push nothing, leave the mode byte, A20 and the write target as they were, and raise no strobe.
- R12: A data-port write with no recorded target drives `kbd_tx_valid` for one cycle with the written byte.
- R13: Every push is a single-cycle `push_valid`, one cycle after the bus write, with `push_aux` = 0 for the keyboard queue and 1 for the auxiliary queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| kbd_pending | input | 1 | Keyboard stream has a byte |
| aux_pending | input | 1 | Auxiliary stream has a byte |
| kbd_rx_byte | input | 8 | Head byte of the keyboard stream |
| aux_rx_byte | input | 8 | Head byte of the auxiliary stream |
| kbd_pop | output | 1 | Pop the keyboard stream |
| aux_pop | output | 1 | Pop the auxiliary stream |
| push_valid | output | 1 | Reply byte push strobe |
| push_aux | output | 1 | Push target: 0 keyboard queue, 1 auxiliary queue |
| push_byte | output | 8 | Pushed byte |
| kbd_tx_valid | output | 1 | Byte for the keyboard transmit path |
| kbd_tx_byte | output | 8 | Keyboard transmit byte |
| aux_tx_valid | output | 1 | Byte for the mouse transmit path |
| aux_tx_byte | output | 8 | Mouse transmit byte |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| a20_gate | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| xlate_en | output | 1 | Scan-code translation enable |

## Verification
The bench sweeps all 256 mode bytes against the four pending combinations, so a core that gave the keyboard interrupt to a disabled keyboard, or that raised the auxiliary flag while keyboard data was also waiting, shows the wrong interrupt or status bit. It issues every one of the 256 command bytes that has no defined meaning and checks that the following data write still reaches the keyboard transmit path with the mode byte unchanged. A decoder that latched a stray target or pushed a reply would fail this. Further checks cover the clearing of the write target after one data byte, the composition of the output-port byte under each pending state, and the single-cycle width of the reset request.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;

    // mode byte bit positions
    localparam int MB_KIRQ  = 0;
    localparam int MB_AIRQ  = 1;
    localparam int MB_KOFF  = 4;
    localparam int MB_AOFF  = 5;
    localparam int MB_XLATE = 6;

    // controller command codes
    localparam logic [7:0] OP_MODE_RD   = 8'h20;
    localparam logic [7:0] OP_MODE_WR   = 8'h60;
    localparam logic [7:0] OP_AUX_OFF   = 8'hA7;
    localparam logic [7:0] OP_AUX_ON    = 8'hA8;
    localparam logic [7:0] OP_AUX_PROBE = 8'hA9;
    localparam logic [7:0] OP_SELFCHK   = 8'hAA;
    localparam logic [7:0] OP_KBD_PROBE = 8'hAB;
    localparam logic [7:0] OP_KBD_OFF   = 8'hAD;
    localparam logic [7:0] OP_KBD_ON    = 8'hAE;
    localparam logic [7:0] OP_INP_RD    = 8'hC0;
    localparam logic [7:0] OP_OUTP_RD   = 8'hD0;
    localparam logic [7:0] OP_OUTP_WR   = 8'hD1;
    localparam logic [7:0] OP_KREPLY    = 8'hD2;
    localparam logic [7:0] OP_AREPLY    = 8'hD3;
    localparam logic [7:0] OP_MOUSE_TX  = 8'hD4;
    localparam logic [7:0] OP_GATE_OFF  = 8'hDD;
    localparam logic [7:0] OP_GATE_ON   = 8'hDF;
    localparam logic [7:0] OP_SYS_RST   = 8'hFE;

    typedef enum logic [2:0] {
        TGT_KBD     = 3'd0,
        TGT_MODE    = 3'd1,
        TGT_OUTPORT = 3'd2,
        TGT_KREPLY  = 3'd3,
        TGT_AREPLY  = 3'd4,
        TGT_MOUSE   = 3'd5
    } wr_tgt_e;

    typedef enum logic [1:0] {
        SRC_CONST = 2'd0,
        SRC_MODE  = 2'd1,
        SRC_OUTP  = 2'd2
    } push_src_e;

    typedef struct packed {
        logic              known;
        logic              set_tgt;
        wr_tgt_e           tgt;
        logic              push;
        push_src_e         src;
        logic [BYTE_W-1:0] cval;
        logic              aoff_set;
        logic              aoff_clr;
        logic              koff_set;
        logic              koff_clr;
        logic              selftest;
        logic              gate_set;
        logic              gate_clr;
        logic              rst_req;
    } cmd_act_t;

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic              selftest;
        logic              a20;
        wr_tgt_e           tgt;
        logic              push_v;
        logic              push_aux;
        logic [BYTE_W-1:0] push_b;
        logic              ktx_v;
        logic [BYTE_W-1:0] ktx_b;
        logic              atx_v;
        logic [BYTE_W-1:0] atx_b;
        logic              rst_req;
    } core_st_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output cmd_act_t          act
);
    always_comb begin
        act      = '0;
        act.tgt  = TGT_KBD;
        act.src  = SRC_CONST;
        act.known = 1'b1;
        unique case (cmd)
            OP_MODE_RD:   begin act.push = 1'b1; act.src = SRC_MODE; end
            OP_MODE_WR:   begin act.set_tgt = 1'b1; act.tgt = TGT_MODE; end
            OP_OUTP_WR:   begin act.set_tgt = 1'b1; act.tgt = TGT_OUTPORT; end
            OP_KREPLY:    begin act.set_tgt = 1'b1; act.tgt = TGT_KREPLY; end
            OP_AREPLY:    begin act.set_tgt = 1'b1; act.tgt = TGT_AREPLY; end
            OP_MOUSE_TX:  begin act.set_tgt = 1'b1; act.tgt = TGT_MOUSE; end
            OP_AUX_OFF:   act.aoff_set = 1'b1;
            OP_AUX_ON:    act.aoff_clr = 1'b1;
            OP_KBD_OFF:   act.koff_set = 1'b1;
            OP_KBD_ON:    act.koff_clr = 1'b1;
            OP_SELFCHK:   begin act.selftest = 1'b1; act.push = 1'b1; act.cval = 8'h55; end
            OP_AUX_PROBE,
            OP_KBD_PROBE,
            OP_INP_RD:    begin act.push = 1'b1; act.cval = 8'h00; end
            OP_OUTP_RD:   begin act.push = 1'b1; act.src = SRC_OUTP; end
            OP_GATE_ON:   act.gate_set = 1'b1;
            OP_GATE_OFF:  act.gate_clr = 1'b1;
            OP_SYS_RST:   act.rst_req = 1'b1;
            default:      act.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/kbc_stream_arb.sv
module kbc_stream_arb
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_pending,
    input  logic              aux_pending,
    input  logic [BYTE_W-1:0] kbd_rx_byte,
    input  logic [BYTE_W-1:0] aux_rx_byte,
    input  logic [BYTE_W-1:0] mode,
    input  logic              selftest,
    output logic              obf,
    output logic              aux_only,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_sel,
    output logic              irq_kbd,
    output logic              irq_aux
);
    always_comb begin
        aux_only = aux_pending & ~kbd_pending;
        obf      = aux_pending | kbd_pending;
        rx_sel   = aux_only ? aux_rx_byte : kbd_rx_byte;
        status   = {2'b00, aux_only, 1'b1, 1'b1, selftest, 1'b0, obf};
        irq_aux  = aux_only & mode[MB_AIRQ];
        irq_kbd  = kbd_pending & mode[MB_KIRQ] & ~mode[MB_KOFF];
    end

    assert_irq_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_kbd && irq_aux));

    assert_auxflag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> (status[0] && !kbd_pending));
endmodule

// File: rtl/kbc_host_core.sv
module kbc_host_core
    import kbc_pkg::*;
#(
    parameter logic [7:0] MODE_INIT = 8'h03,
    parameter logic       A20_INIT  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       kbd_pending,
    input  logic       aux_pending,
    input  logic [7:0] kbd_rx_byte,
    input  logic [7:0] aux_rx_byte,
    output logic       kbd_pop,
    output logic       aux_pop,
    output logic       push_valid,
    output logic       push_aux,
    output logic [7:0] push_byte,
    output logic       kbd_tx_valid,
    output logic [7:0] kbd_tx_byte,
    output logic       aux_tx_valid,
    output logic [7:0] aux_tx_byte,
    output logic       irq_kbd,
    output logic       irq_aux,
    output logic       a20_gate,
    output logic       sys_reset_req,
    output logic       xlate_en
);
    core_st_t st_d, st_q;
    cmd_act_t act;

    logic              obf, aux_only;
    logic [BYTE_W-1:0] status, rx_sel, outp_byte;
    logic              cmd_wr, dat_wr, dat_rd;

    assign cmd_wr = bus_wr & bus_addr;
    assign dat_wr = bus_wr & ~bus_addr;
    assign dat_rd = bus_rd & ~bus_addr;

    kbc_cmd_decode u_dec (
        .cmd (bus_wdata),
        .act (act)
    );

    kbc_stream_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .kbd_pending (kbd_pending),
        .aux_pending (aux_pending),
        .kbd_rx_byte (kbd_rx_byte),
        .aux_rx_byte (aux_rx_byte),
        .mode        (st_q.mode),
        .selftest    (st_q.selftest),
        .obf         (obf),
        .aux_only    (aux_only),
        .status      (status),
        .rx_sel      (rx_sel),
        .irq_kbd     (irq_kbd),
        .irq_aux     (irq_aux)
    );

    assign outp_byte = {2'b00, aux_only, obf, 2'b00, st_q.a20, 1'b1};

    always_comb begin
        st_d         = st_q;
        st_d.push_v  = 1'b0;
        st_d.ktx_v   = 1'b0;
        st_d.atx_v   = 1'b0;
        st_d.rst_req = 1'b0;
        if (cmd_wr) begin
            if (act.set_tgt) st_d.tgt = act.tgt;
            if (act.aoff_set) st_d.mode[MB_AOFF] = 1'b1;
            if (act.aoff_clr) st_d.mode[MB_AOFF] = 1'b0;
            if (act.koff_set) st_d.mode[MB_KOFF] = 1'b1;
            if (act.koff_clr) st_d.mode[MB_KOFF] = 1'b0;
            if (act.selftest) st_d.selftest = 1'b1;
            if (act.gate_set) st_d.a20 = 1'b1;
            if (act.gate_clr) st_d.a20 = 1'b0;
            st_d.rst_req = act.rst_req;
            if (act.push) begin
                st_d.push_v   = 1'b1;
                st_d.push_aux = 1'b0;
                unique case (act.src)
                    SRC_MODE: st_d.push_b = st_q.mode;
                    SRC_OUTP: st_d.push_b = outp_byte;
                    default:  st_d.push_b = act.cval;
                endcase
            end
        end else if (dat_wr) begin
            unique case (st_q.tgt)
                TGT_MODE:    st_d.mode = bus_wdata;
                TGT_OUTPORT: begin
                    st_d.a20     = bus_wdata[1];
                    st_d.rst_req = ~bus_wdata[0];
                end
                TGT_KREPLY:  begin
                    st_d.push_v = 1'b1; st_d.push_aux = 1'b0; st_d.push_b = bus_wdata;
                end
                TGT_AREPLY:  begin
                    st_d.push_v = 1'b1; st_d.push_aux = 1'b1; st_d.push_b = bus_wdata;
                end
                TGT_MOUSE:   begin
                    st_d.atx_v = 1'b1; st_d.atx_b = bus_wdata;
                end
                default:     begin
                    st_d.ktx_v = 1'b1; st_d.ktx_b = bus_wdata;
                end
            endcase
            st_d.tgt = TGT_KBD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_INIT;
            st_q.a20      <= A20_INIT;
            st_q.tgt      <= TGT_KBD;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata     = bus_addr ? status : rx_sel;
    assign kbd_pop       = dat_rd & kbd_pending;
    assign aux_pop       = dat_rd & aux_only;
    assign push_valid    = st_q.push_v;
    assign push_aux      = st_q.push_aux;
    assign push_byte     = st_q.push_b;
    assign kbd_tx_valid  = st_q.ktx_v;
    assign kbd_tx_byte   = st_q.ktx_b;
    assign aux_tx_valid  = st_q.atx_v;
    assign aux_tx_byte   = st_q.atx_b;
    assign a20_gate      = st_q.a20;
    assign sys_reset_req = st_q.rst_req;
    assign xlate_en      = st_q.mode[MB_XLATE];

    assert_pop_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_pop && aux_pop));

    assert_target_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> (st_q.tgt == TGT_KBD));

    assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr));

    assert_push_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(bus_wr));

    assert_ignore_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !act.known) |=> ($stable(st_q.mode) && $stable(a20_gate)
                                    && !push_valid && !sys_reset_req));

    assert_tx_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_tx_valid, aux_tx_valid, push_valid}));
endmodule

// File: tb/kbc_host_core_bench.sv
`timescale 1ns/1ps
module kbc_host_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       kbd_pending = 1'b0, aux_pending = 1'b0;
    logic [7:0] kbd_rx_byte = 8'h3C, aux_rx_byte = 8'hC3;
    logic       kbd_pop, aux_pop, push_valid, push_aux;
    logic [7:0] push_byte, kbd_tx_byte, aux_tx_byte;
    logic       kbd_tx_valid, aux_tx_valid, irq_kbd, irq_aux;
    logic       a20_gate, sys_reset_req, xlate_en;

    int checks = 0;
    int errors = 0;

    // captured registered outputs one cycle after a write
    logic       c_pv, c_pa, c_kv, c_av, c_rst;
    logic [7:0] c_pb, c_kb, c_ab;

    always #4 clk = ~clk;

    kbc_host_core u_kbc_host_core (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        c_pv = push_valid; c_pa = push_aux; c_pb = push_byte;
        c_kv = kbd_tx_valid; c_kb = kbd_tx_byte;
        c_av = aux_tx_valid; c_ab = aux_tx_byte; c_rst = sys_reset_req;
    endtask

    task automatic rd_port(input logic a, output logic [7:0] v, output logic kp, output logic ap);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata; kp = kbd_pop; ap = aux_pop;
        bus_rd = 1'b0;
    endtask

    task automatic read_mode(input logic [7:0] exp, input string req);
        wr(1'b1, 8'h20);
        chk(req, {c_pv, c_pa, c_pb}, {1'b1, 1'b0, exp});
    endtask

    function automatic logic is_known(input logic [7:0] c);
        case (c)
            8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
            8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF, 8'hFE:
                return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic kp, ap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_port(1'b1, v, kp, ap);
        chk("R1 status", v, 8'h18);
        chk("R1 a20/xlate/irq", {a20_gate, xlate_en, irq_kbd, irq_aux}, 4'b0);
        read_mode(8'h03, "R1 mode");

        // R2 R3 R4 R10 sweep of every mode byte against every pending combination
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'h60);
            wr(1'b0, m[7:0]);
            chk("R12 mode write not forwarded", c_kv, 1'b0);
            chk("R10 xlate", xlate_en, m[6]);
            read_mode(m[7:0], "R5 R6 mode readback");
            for (int p = 0; p < 4; p++) begin
                logic kk, aa, only;
                kk = p[0]; aa = p[1]; only = aa & ~kk;
                @(negedge clk);
                kbd_pending = kk; aux_pending = aa;
                #1;
                chk("R3 irq_kbd", irq_kbd, kk & m[0] & ~m[4]);
                chk("R3 irq_aux", irq_aux, only & m[1]);
                rd_port(1'b1, v, kp, ap);
                chk("R2 status", v, {2'b00, only, 2'b11, 1'b0, 1'b0, kk | aa});
                rd_port(1'b0, v, kp, ap);
                chk("R4 data", v, only ? 8'hC3 : 8'h3C);
                chk("R4 pops", {kp, ap}, {kk, only});
            end
            kbd_pending = 1'b0; aux_pending = 1'b0;
        end

        // R11 every undefined command is ignored
        wr(1'b1, 8'h60); wr(1'b0, 8'h47);
        for (int c = 0; c < 256; c++) begin
            if (!is_known(c[7:0])) begin
                wr(1'b1, c[7:0]);
                chk("R11 no strobe", {c_pv, c_kv, c_av, c_rst}, 4'b0);
                chk("R11 a20", a20_gate, 1'b0);
                wr(1'b0, 8'h5A);
                chk("R11 R12 target untouched", {c_kv, c_kb, c_av, c_pv}, {1'b1, 8'h5A, 2'b00});
                read_mode(8'h47, "R11 mode unchanged");
            end
        end

        // R5 R9 output port writes
        wr(1'b1, 8'hD1); chk("R5 latch only", {c_pv, c_kv, c_av, c_rst}, 4'b0);
        wr(1'b0, 8'h03); chk("R9 outport a20", {a20_gate, c_rst}, 2'b10);
        wr(1'b1, 8'hD1); wr(1'b0, 8'h00);
        chk("R9 outport reset", {a20_gate, c_rst}, 2'b01);
        @(negedge clk); chk("R9 reset pulse width", sys_reset_req, 1'b0);
        // R5 reply queues and mouse path, then target clears
        wr(1'b1, 8'hD2); wr(1'b0, 8'h77);
        chk("R5 R13 kreply", {c_pv, c_pa, c_pb}, {2'b10, 8'h77});
        @(negedge clk); chk("R13 push one cycle", push_valid, 1'b0);
        wr(1'b1, 8'hD3); wr(1'b0, 8'h88);
        chk("R5 R13 areply", {c_pv, c_pa, c_pb}, {2'b11, 8'h88});
        wr(1'b1, 8'hD4); wr(1'b0, 8'h99);
        chk("R5 mouse tx", {c_av, c_ab, c_kv}, {1'b1, 8'h99, 1'b0});
        wr(1'b0, 8'h11);
        chk("R5 R12 target cleared", {c_kv, c_kb, c_av}, {1'b1, 8'h11, 1'b0});

        // R9 gate commands and reset command
        wr(1'b1, 8'hDF); chk("R9 gate on", a20_gate, 1'b1);
        wr(1'b1, 8'hDD); chk("R9 gate off", a20_gate, 1'b0);
        wr(1'b1, 8'hFE); chk("R9 reset cmd", c_rst, 1'b1);
        @(negedge clk); chk("R9 reset cmd pulse", sys_reset_req, 1'b0);

        // R6 reply commands
        wr(1'b1, 8'hA9); chk("R6 A9", {c_pv, c_pa, c_pb}, {2'b10, 8'h00});
        wr(1'b1, 8'hAB); chk("R6 AB", {c_pv, c_pa, c_pb}, {2'b10, 8'h00});
        wr(1'b1, 8'hC0); chk("R6 C0", {c_pv, c_pa, c_pb}, {2'b10, 8'h00});
        wr(1'b1, 8'hAA); chk("R6 AA", {c_pv, c_pa, c_pb}, {2'b10, 8'h55});
        rd_port(1'b1, v, kp, ap); chk("R6 R2 selftest bit", v, 8'h1C);

        // R7 mode bit commands
        wr(1'b1, 8'h60); wr(1'b0, 8'h03);
        wr(1'b1, 8'hA7); read_mode(8'h23, "R7 A7");
        wr(1'b1, 8'hA8); read_mode(8'h03, "R7 A8");
        kbd_pending = 1'b1;
        #1; chk("R7 irq before disable", irq_kbd, 1'b1);
        wr(1'b1, 8'hAD); chk("R7 AD irq drops", irq_kbd, 1'b0);
        read_mode(8'h13, "R7 AD mode");
        wr(1'b1, 8'hAE); chk("R7 AE irq returns", irq_kbd, 1'b1);

        // R8 output port byte under each pending state and A20 level
        for (int g = 0; g < 2; g++) begin
            wr(1'b1, g[0] ? 8'hDF : 8'hDD);
            for (int p = 0; p < 4; p++) begin
                logic kk, aa;
                kk = p[0]; aa = p[1];
                @(negedge clk);
                kbd_pending = kk; aux_pending = aa;
                wr(1'b1, 8'hD0);
                chk("R8 outport byte", {c_pv, c_pa, c_pb},
                    {2'b10, 2'b00, aa & ~kk, kk | aa, 2'b00, g[0], 1'b1});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule